// File: doc/BRIEF.md
# Serial I/Q Sample Capture Selector

This block receives a bit-serial stream from a digital down-converter. The converter sends one frame of four 24-bit words on a single serial line. The frame holds the in-phase (I) and quadrature (Q) samples of two channels. The block keeps the words that belong to one chosen channel and phase and turns each kept word into a write strobe for a sample memory. It counts the writes and raises a done flag when the memory is full.

Everything runs on the serial bit clock. A frame strobe marks where each frame begins. An alignment input chooses where the first bit of the frame falls: in the same bit period as the strobe, or in the period after it. Software picks a channel and a phase mode and then pulses start. In alternating mode the block stores I and Q words in turn, so the memory holds half as many samples of each phase. By default the memory holds 32K words, so alternating mode stores 16K of each phase.

Top module: `iq_capture_sel`

## Requirements
- R1: While reset is low and right after it is released, mem_we is 0, done is 0 and mem_addr is 0.
- R2: A word is 24 bits long and arrives most significant bit first, one bit per clock. The value on mem_data is the whole received word.
- R3: When first_bit is 1, the bit sampled in the cycle where fstrobe is high is the MSB of the first word. When first_bit is 0, that bit is discarded and the MSB of the first word is the bit sampled in the next cycle.
- R4: A frame holds four back-to-back words in a fixed order: slot 0 is channel A I, slot 1 is channel A Q, slot 2 is channel B I, slot 3 is channel B Q. ch_sel set to 0 selects channel A and 1 selects channel B. After slot 3 the block ignores the line until the next strobe.
- R5: phase_mode 2'b00 stores only I words of the chosen channel. phase_mode 2'b01 stores only Q words.
- R6: When phase_mode[1] is 1, stored words alternate I then Q. The sequence begins with the first I word after start.
- R7: Write addresses start at 0 after start and rise by one with each write.
- R8: After 2**ADDR_W writes, done goes high in the same cycle as the last write pulse. No further writes happen, and done stays high until the next start.
- R9: A start pulse clears done and restarts capture at address 0.
- R10: No writes happen before the first start after reset, whatever the serial line carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; data is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial sample data, MSB first |
| fstrobe | input | 1 | Frame start marker, one bit period wide |
| first_bit | input | 1 | 1: frame starts on the strobe bit; 0: frame starts on the bit after it |
| ch_sel | input | 1 | Channel to store (0 = A, 1 = B) |
| phase_mode | input | 2 | 00 = I only, 01 = Q only, 1x = alternating I/Q |
| start | input | 1 | One-cycle pulse that starts a capture |
| mem_addr | output | ADDR_W | Write address of the sample memory |
| mem_data | output | WORD_W | Write data of the sample memory |
| mem_we | output | 1 | One-cycle write enable |
| done | output | 1 | High once the memory is full, until the next start |

## Verification
The bench sends random frames with both alignments, both channels and every phase mode, and compares each write against a model held in the bench. One directed case sends frames before any start; a design that stores them would write junk. When first_bit is 0, the strobe bit carries random data, so an off-by-one alignment shifts every word and its data check fails. In alternating mode the run goes past a full memory. A design that fills the memory one write late or early, writes after done, or restarts with Q instead of I gives a wrong write count or an out-of-order word.

// File: rtl/iq_capture_sel.sv
module iq_capture_sel #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              fstrobe,
  input  logic              first_bit,
  input  logic              ch_sel,
  input  logic [1:0]        phase_mode,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              mem_we,
  output logic              done
);
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  logic              fs_q, active, capturing, want_q;
  logic [BC_W-1:0]   bcnt;
  logic [1:0]        slot;
  logic [WORD_W-2:0] shreg;
  logic [ADDR_W-1:0] waddr;

  wire fs_eff   = first_bit ? fstrobe : fs_q;
  wire word_end = active && !fs_eff && (bcnt == LAST_BIT);
  wire [WORD_W-1:0] word = {shreg, sdata};
  wire alt      = phase_mode[1];
  wire want     = (slot[1] == ch_sel) && (alt ? (slot[0] == want_q) : (slot[0] == phase_mode[0]));
  wire wr       = capturing && word_end && want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      active <= 1'b0;
      bcnt   <= '0;
      slot   <= '0;
      shreg  <= '0;
    end else begin
      fs_q <= fstrobe;
      if (fs_eff) begin
        active <= 1'b1;
        bcnt   <= BC_W'(1);
        slot   <= 2'd0;
        shreg  <= {shreg[WORD_W-3:0], sdata};
      end else if (active) begin
        shreg <= {shreg[WORD_W-3:0], sdata};
        if (bcnt == LAST_BIT) begin
          bcnt <= '0;
          slot <= slot + 2'd1;
          if (slot == 2'd3) active <= 1'b0;
        end else begin
          bcnt <= bcnt + BC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capturing <= 1'b0;
      want_q    <= 1'b0;
      waddr     <= '0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start) begin
        capturing <= 1'b1;
        want_q    <= 1'b0;
        waddr     <= '0;
        done      <= 1'b0;
      end else if (wr) begin
        mem_we   <= 1'b1;
        mem_data <= word;
        mem_addr <= waddr;
        waddr    <= waddr + ADDR_W'(1);
        want_q   <= ~want_q;
        if (&waddr) begin
          done      <= 1'b1;
          capturing <= 1'b0;
        end
      end
    end
  end

  logic [ADDR_W-1:0] chk_last;
  logic              chk_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_last <= '0;
      chk_seen <= 1'b0;
    end else if (start) begin
      chk_seen <= 1'b0;
    end else if (mem_we) begin
      chk_last <= mem_addr;
      chk_seen <= 1'b1;
    end
  end

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && chk_seen) |-> (mem_addr == chk_last + ADDR_W'(1)));
  a_r8_quiet_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && done) |-> !mem_we);
  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !mem_we));
  a_r7_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !chk_seen) |-> (mem_addr == '0));
endmodule

// File: tb/sim_iq_capture_sel.sv
module sim_iq_capture_sel;
  localparam int WW = 24;
  localparam int AW = 5;
  localparam int FULL = 1 << AW;

  logic clk = 0, rst_n = 0, sdata = 0, fstrobe = 0, first_bit = 1, ch_sel = 0, start = 0;
  logic [1:0] phase_mode = 2'b00;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_data;
  logic mem_we, done;

  iq_capture_sel #(.WORD_W(WW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .fstrobe(fstrobe), .first_bit(first_bit),
    .ch_sel(ch_sel), .phase_mode(phase_mode), .start(start),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we), .done(done));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int ng = 0, ne = 0;
  logic [WW-1:0] got_d [64];
  logic [AW-1:0] got_a [64];
  logic [WW-1:0] exp_d [64];
  logic [WW-1:0] fw [4];
  bit b_cap = 0, b_eq = 0, b_done = 0;
  int b_cnt = 0;

  always @(negedge clk) if (mem_we) begin
    if (ng < 64) begin got_d[ng] = mem_data; got_a[ng] = mem_addr; end
    ng++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit selected(input int s);
    if (s / 2 != int'(ch_sel)) return 0;
    if (phase_mode[1]) return (s % 2) == int'(b_eq);
    return (s % 2) == int'(phase_mode[0]);
  endfunction

  task automatic model_frame();
    for (int s = 0; s < 4; s++)
      if (b_cap && selected(s)) begin
        if (ne < 64) exp_d[ne] = fw[s];
        ne++; b_cnt++; b_eq = ~b_eq;
        if (b_cnt == FULL) begin b_done = 1; b_cap = 0; end
      end
  endtask

  task automatic send_frame();
    for (int s = 0; s < 4; s++) fw[s] = WW'($urandom);
    model_frame();
    if (!first_bit) begin
      @(negedge clk); fstrobe = 1; sdata = 1'($urandom);
    end
    for (int s = 0; s < 4; s++)
      for (int b = WW - 1; b >= 0; b--) begin
        @(negedge clk);
        fstrobe = first_bit && s == 0 && b == WW - 1;
        sdata = fw[s][b];
      end
    @(negedge clk); fstrobe = 0; sdata = 1'($urandom);
    repeat (1 + $urandom % 3) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    b_cap = 1; b_cnt = 0; b_eq = 0; b_done = 0;
    chk(done == 0, "R9", "done after start", 32'(done), 0);
  endtask

  task automatic check_run(input string req);
    repeat (3) @(negedge clk);
    chk(ng == ne, req, "write count", ng, ne);
    for (int i = 0; i < ne && i < ng && i < 64; i++) begin
      chk(got_d[i] == exp_d[i], req, "word data", 32'(got_d[i]), 32'(exp_d[i]));
      chk(int'(got_a[i]) == i, "R7", "address", 32'(got_a[i]), i);
    end
    chk(done == b_done, "R8", "done flag", 32'(done), 32'(b_done));
    ng = 0; ne = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(mem_we == 0 && done == 0 && mem_addr == 0, "R1", "reset outputs", {mem_we, done, 30'(mem_addr)}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_we == 0 && done == 0 && mem_addr == 0, "R1", "after release", {mem_we, done, 30'(mem_addr)}, 0);

    // R10: frames before any start leave memory untouched
    for (int f = 0; f < 3; f++) send_frame();
    check_run("R10");

    // R2 R4 R5: I only, channel A, strobe-aligned
    first_bit = 1; ch_sel = 0; phase_mode = 2'b00;
    do_start();
    for (int f = 0; f < 8; f++) send_frame();
    check_run("R5");

    // R3 R4 R5: Q only, channel B, frame starts after strobe bit
    first_bit = 0; ch_sel = 1; phase_mode = 2'b01;
    do_start();
    for (int f = 0; f < 8; f++) send_frame();
    check_run("R3");

    // R6 R8: alternating channel A, run past full memory
    first_bit = 1; ch_sel = 0; phase_mode = 2'b10;
    do_start();
    for (int f = 0; f < FULL / 2 + 3; f++) send_frame();
    check_run("R6");
    chk(done == 1, "R8", "done held when full", 32'(done), 1);

    // R9: restart clears done, mixed random settings
    for (int r = 0; r < 3; r++) begin
      first_bit = 1'($urandom); ch_sel = 1'($urandom); phase_mode = 2'($urandom);
      do_start();
      for (int f = 0; f < 4; f++) send_frame();
      check_run("R9");
    end

    // R6 R8 again with other alignment and channel B
    first_bit = 0; ch_sel = 1; phase_mode = 2'b11;
    do_start();
    for (int f = 0; f < FULL / 2 + 1; f++) send_frame();
    check_run("R6");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule